// File: doc/BRIEF.md
# Composite Sync Separator and Pixel Sampler

This block sits behind a one-bit comparator that watches the luma signal of a retro video generator. The comparator output is low whenever the luma is below the black threshold. From that single bit the block recovers horizontal line timing and vertical frame timing. For each visible line it then produces a regular train of sample strobes, so that an external converter can capture every active pixel. The block is clocked by the video generator's own master clock, about 10.7 MHz. Sampling therefore stays phase-locked to the pixel stream, and no recovery loop is needed.

The raw input first passes through a two-stage synchronizer and a majority-free glitch filter that needs a run of identical samples. The filtered level drives a low-duration timer that spots the long vertical sync interval, and a line tracker that counts horizontal sync edges from the start of the frame. Only lines inside a configurable window of the frame receive strobes. Each of those lines gets a fixed number of strobes, beginning a programmable delay after the sync edge and spaced by a fixed clock divider. A line-done pulse follows the last strobe, so that downstream logic has the rest of the line to process what it captured.

Top module: `vsep_top`

## Requirements
- R1: While reset is high and in the cycle after it is released, `sample_o`, `line_start_o`, `line_done_o` and `frame_start_o` are 0, and `pixel_o` and `line_o` are 0.
- R2: For a falling edge that starts a sampled line, `line_start_o` is high for exactly one cycle: the cycle that follows the (FILT_LEN+4)-th rising clock edge after `sync_n_i` goes low (the edge that samples the low counts as the first).
- R3: A low pulse on `sync_n_i` shorter than FILT_LEN cycles is ignored. It produces no `line_start_o` and no strobe, and it does not advance the line numbering.
- R4: The first `sample_o` of a line comes exactly SAMPLE_DELAY cycles after the cycle in which `line_start_o` is high.
- R5: A sampled line receives exactly PIX_PER_LINE strobes, spaced PIX_DIV cycles apart. `pixel_o` reads 0, 1, 2, ... in order with each strobe.
- R6: `line_done_o` is a one-cycle pulse that comes PIX_DIV cycles after the last strobe of a line, and exactly one such pulse is given per sampled line.
- R7: Only the sync edges numbered SKIP_LINES up to SKIP_LINES+ACTIVE_LINES-1 after a frame start (counting from 0) start sampled lines. `line_o` at `line_start_o` gives 0 up to ACTIVE_LINES-1 for them. No line is sampled before the first frame start.
- R8: A filtered low lasting VSYNC_CLKS cycles gives one `frame_start_o` pulse of one cycle. It stops any line in progress and restarts line numbering. A shorter low gives no frame start.
- R9: Once a frame start has been flagged, falling edges are ignored, and no further frame start is given, until the filtered input has been high for VS_EXIT_CLKS cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Video master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_n_i | input | 1 | Comparator output, low while luma is below black |
| sample_o | output | 1 | Pixel sample strobe |
| pixel_o | output | clog2(PIX_PER_LINE) | Index of the pixel being strobed |
| line_o | output | clog2(ACTIVE_LINES) | Active line index, valid with line_start_o |
| line_start_o | output | 1 | One-cycle pulse at the start of a sampled line |
| line_done_o | output | 1 | One-cycle pulse after the last strobe of a line |
| frame_start_o | output | 1 | One-cycle pulse when vertical sync is recognised |

## Verification
A wrong filter or synchronizer depth shows at once as a `line_start_o` one or more cycles away from the expected edge. Too short a filter also lets a short glitch start a line, which then shows up as an extra line index on the next real line. A wrong delay counter or pixel divider moves the first strobe or breaks the strobe spacing within the first line after a frame, and a wrong terminal count shows as a wrong strobe total at `line_done_o`. A fault in the line window or the vertical-interval logic shows within one frame: lines are numbered wrongly, there is an extra or missing `frame_start_o`, or lines start inside the serrated sync interval.

// File: rtl/vsep_pkg.sv
package vsep_pkg;

    typedef enum logic [1:0] {
        PX_IDLE   = 2'd0,
        PX_WAIT   = 2'd1,
        PX_ACTIVE = 2'd2
    } px_state_e;

    typedef struct packed {
        logic level;
        logic fall;
    } sync_ev_t;

    typedef struct packed {
        logic go;
        logic frame;
    } line_ev_t;

    function automatic int unsigned cw(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vsep_sync_filter.sv
module vsep_sync_filter
    import vsep_pkg::*;
#(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     sync_n_i,
    output sync_ev_t ev_o
);

    logic [1:0]          meta_q;
    logic [FILT_LEN-1:0] hist_q;
    logic                lvl_q;
    logic                lvl_d_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q  <= '1;
            hist_q  <= '1;
            lvl_q   <= 1'b1;
            lvl_d_q <= 1'b1;
        end else begin
            meta_q  <= {meta_q[0], sync_n_i};
            hist_q  <= {hist_q[FILT_LEN-2:0], meta_q[1]};
            if (&hist_q)
                lvl_q <= 1'b1;
            else if (~|hist_q)
                lvl_q <= 1'b0;
            lvl_d_q <= lvl_q;
        end
    end

    assign ev_o.level = lvl_q;
    assign ev_o.fall  = lvl_d_q & ~lvl_q;

endmodule

// File: rtl/vsep_frame_track.sv
module vsep_frame_track
    import vsep_pkg::*;
#(
    parameter int unsigned VSYNC_CLKS   = 684,
    parameter int unsigned VS_EXIT_CLKS = 32,
    parameter int unsigned SKIP_LINES   = 27,
    parameter int unsigned ACTIVE_LINES = 192
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  sync_ev_t                    ev_i,
    output line_ev_t                    lev_o,
    output logic                        line_start_o,
    output logic                        frame_start_o,
    output logic [cw(ACTIVE_LINES)-1:0] line_o
);

    localparam int unsigned LOW_W  = cw(VSYNC_CLKS);
    localparam int unsigned HIGH_W = cw(VS_EXIT_CLKS);
    localparam int unsigned HC_W   = cw(SKIP_LINES + ACTIVE_LINES + 1);
    localparam int unsigned LN_W   = cw(ACTIVE_LINES);
    localparam logic [LOW_W-1:0]  LOW_MAX  = LOW_W'(VSYNC_CLKS - 1);
    localparam logic [HIGH_W-1:0] HIGH_MAX = HIGH_W'(VS_EXIT_CLKS - 1);
    localparam logic [HC_W-1:0]   SKIP_V   = HC_W'(SKIP_LINES);
    localparam logic [HC_W-1:0]   END_V    = HC_W'(SKIP_LINES + ACTIVE_LINES);

    logic [LOW_W-1:0]  low_cnt_q;
    logic [HIGH_W-1:0] high_cnt_q;
    logic [HC_W-1:0]   hcount_q;
    logic              in_vs_q;
    logic              detect, leave, hsync_ok, lo_ok, in_window;

    generate
        if (SKIP_LINES == 0) begin : g_noskip
            assign lo_ok = 1'b1;
        end else begin : g_skip
            assign lo_ok = (hcount_q >= SKIP_V);
        end
    endgenerate

    assign detect    = ~ev_i.level & (low_cnt_q == LOW_MAX) & ~in_vs_q;
    assign leave     = ev_i.level & (high_cnt_q == HIGH_MAX) & in_vs_q;
    assign hsync_ok  = ev_i.fall & ~in_vs_q;
    assign in_window = lo_ok & (hcount_q < END_V);

    assign lev_o.go    = hsync_ok & in_window;
    assign lev_o.frame = detect;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            low_cnt_q     <= '0;
            high_cnt_q    <= '0;
            hcount_q      <= END_V;
            in_vs_q       <= 1'b0;
            line_start_o  <= 1'b0;
            frame_start_o <= 1'b0;
            line_o        <= '0;
        end else begin
            if (ev_i.level)
                low_cnt_q <= '0;
            else if (low_cnt_q != LOW_MAX)
                low_cnt_q <= low_cnt_q + 1'b1;

            if (!ev_i.level)
                high_cnt_q <= '0;
            else if (high_cnt_q != HIGH_MAX)
                high_cnt_q <= high_cnt_q + 1'b1;

            frame_start_o <= detect;
            line_start_o  <= lev_o.go;
            if (lev_o.go)
                line_o <= LN_W'(hcount_q - SKIP_V);

            if (detect) begin
                in_vs_q  <= 1'b1;
                hcount_q <= '0;
            end else begin
                if (leave)
                    in_vs_q <= 1'b0;
                if (hsync_ok && hcount_q != END_V)
                    hcount_q <= hcount_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vsep_pixel_gen.sv
module vsep_pixel_gen
    import vsep_pkg::*;
#(
    parameter int unsigned SAMPLE_DELAY = 128,
    parameter int unsigned PIX_PER_LINE = 256,
    parameter int unsigned PIX_DIV      = 2
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  line_ev_t                    lev_i,
    output logic                        sample_o,
    output logic [cw(PIX_PER_LINE)-1:0] pixel_o,
    output logic                        line_done_o
);

    localparam int unsigned DLY_W = cw(SAMPLE_DELAY);
    localparam int unsigned PIX_W = cw(PIX_PER_LINE);
    localparam int unsigned PH_W  = cw(PIX_DIV);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(SAMPLE_DELAY - 1);
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(PIX_PER_LINE - 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PIX_DIV - 1);

    px_state_e        st_q;
    logic [DLY_W-1:0] dly_q;
    logic [PIX_W-1:0] pix_q;
    logic [PH_W-1:0]  ph_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q        <= PX_IDLE;
            dly_q       <= '0;
            pix_q       <= '0;
            ph_q        <= '0;
            line_done_o <= 1'b0;
        end else begin
            line_done_o <= 1'b0;
            if (lev_i.frame) begin
                st_q <= PX_IDLE;
            end else if (lev_i.go) begin
                st_q  <= PX_WAIT;
                dly_q <= '0;
            end else begin
                unique case (st_q)
                    PX_WAIT: begin
                        if (dly_q == DLY_LAST) begin
                            st_q  <= PX_ACTIVE;
                            ph_q  <= '0;
                            pix_q <= '0;
                        end else begin
                            dly_q <= dly_q + 1'b1;
                        end
                    end
                    PX_ACTIVE: begin
                        if (ph_q == PH_LAST) begin
                            ph_q <= '0;
                            if (pix_q == PIX_LAST) begin
                                st_q        <= PX_IDLE;
                                line_done_o <= 1'b1;
                            end else begin
                                pix_q <= pix_q + 1'b1;
                            end
                        end else begin
                            ph_q <= ph_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sample_o = (st_q == PX_ACTIVE) && (ph_q == '0);
    assign pixel_o  = pix_q;

endmodule

// File: rtl/vsep_top.sv
module vsep_top
    import vsep_pkg::*;
#(
    parameter int unsigned FILT_LEN     = 3,
    parameter int unsigned SAMPLE_DELAY = 128,
    parameter int unsigned PIX_PER_LINE = 256,
    parameter int unsigned PIX_DIV      = 2,
    parameter int unsigned ACTIVE_LINES = 192,
    parameter int unsigned SKIP_LINES   = 27,
    parameter int unsigned VSYNC_CLKS   = 684,
    parameter int unsigned VS_EXIT_CLKS = 32
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        sync_n_i,
    output logic                        sample_o,
    output logic [cw(PIX_PER_LINE)-1:0] pixel_o,
    output logic [cw(ACTIVE_LINES)-1:0] line_o,
    output logic                        line_start_o,
    output logic                        line_done_o,
    output logic                        frame_start_o
);

    sync_ev_t ev;
    line_ev_t lev;

    vsep_sync_filter #(.FILT_LEN(FILT_LEN)) filt_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .sync_n_i (sync_n_i),
        .ev_o     (ev)
    );

    vsep_frame_track #(
        .VSYNC_CLKS   (VSYNC_CLKS),
        .VS_EXIT_CLKS (VS_EXIT_CLKS),
        .SKIP_LINES   (SKIP_LINES),
        .ACTIVE_LINES (ACTIVE_LINES)
    ) trk_i (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .ev_i          (ev),
        .lev_o         (lev),
        .line_start_o  (line_start_o),
        .frame_start_o (frame_start_o),
        .line_o        (line_o)
    );

    vsep_pixel_gen #(
        .SAMPLE_DELAY (SAMPLE_DELAY),
        .PIX_PER_LINE (PIX_PER_LINE),
        .PIX_DIV      (PIX_DIV)
    ) pix_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .lev_i       (lev),
        .sample_o    (sample_o),
        .pixel_o     (pixel_o),
        .line_done_o (line_done_o)
    );

endmodule

// File: rtl/vsep_checker.sv
module vsep_checker #(
    parameter int unsigned PIX_DIV      = 2,
    parameter int unsigned ACTIVE_LINES = 192,
    parameter int unsigned PIX_W        = 8,
    parameter int unsigned LN_W         = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             sample_o,
    input logic [PIX_W-1:0] pixel_o,
    input logic [LN_W-1:0]  line_o,
    input logic             line_start_o,
    input logic             line_done_o,
    input logic             frame_start_o
);

    assert_ls_pulse_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        line_start_o |=> !line_start_o);

    assert_ls_before_strobe_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        line_start_o |-> !sample_o);

    generate
        if (PIX_DIV > 1) begin : g_gap
            assert_strobe_gap_R5: assert property (@(posedge clk_i) disable iff (rst_i)
                sample_o |=> !sample_o);
        end
    endgenerate

    assert_done_quiet_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        line_done_o |-> !sample_o && !line_start_o);

    assert_line_range_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        line_start_o |-> (32'(line_o) < ACTIVE_LINES));

    assert_fs_pulse_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_start_o |=> !frame_start_o);

    assert_fs_abort_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_start_o |=> !sample_o && !line_start_o);

endmodule

bind vsep_top vsep_checker #(
    .PIX_DIV      (PIX_DIV),
    .ACTIVE_LINES (ACTIVE_LINES),
    .PIX_W        (vsep_pkg::cw(PIX_PER_LINE)),
    .LN_W         (vsep_pkg::cw(ACTIVE_LINES))
) chk_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .sample_o      (sample_o),
    .pixel_o       (pixel_o),
    .line_o        (line_o),
    .line_start_o  (line_start_o),
    .line_done_o   (line_done_o),
    .frame_start_o (frame_start_o)
);

// File: tb/vsep_top_tb_top.sv
module vsep_top_tb_top;

    localparam int F   = 3;
    localparam int D   = 6;
    localparam int P   = 8;
    localparam int DIV = 2;
    localparam int ACT = 3;
    localparam int SKP = 1;
    localparam int VS  = 60;
    localparam int VX  = 20;

    logic       clk = 1'b0;
    logic       rst;
    logic       sync_n;
    logic       sample;
    logic [2:0] pixel;
    logic [1:0] line;
    logic       ls, ld, fs;

    always #10 clk = ~clk;

    vsep_top #(
        .FILT_LEN(F), .SAMPLE_DELAY(D), .PIX_PER_LINE(P), .PIX_DIV(DIV),
        .ACTIVE_LINES(ACT), .SKIP_LINES(SKP), .VSYNC_CLKS(VS), .VS_EXIT_CLKS(VX)
    ) dut_i (
        .clk_i(clk), .rst_i(rst), .sync_n_i(sync_n), .sample_o(sample),
        .pixel_o(pixel), .line_o(line), .line_start_o(ls),
        .line_done_o(ld), .frame_start_o(fs)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int n_ls = 0, n_fs = 0, n_str = 0, n_done = 0;
    int ls_cyc = 0, last_str = 0, str_in_line = 0;
    int lines_seen [0:31];
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Port monitor: strobe timing R4, ordering R5, line end R6
    always @(negedge clk) begin
        if (!rst) begin
            if (ls) begin
                if (n_ls < 32) lines_seen[n_ls] = int'(line);
                n_ls++;
                ls_cyc = cyc;
                str_in_line = 0;
            end
            if (sample) begin
                n_str++;
                if (str_in_line == 0)
                    chk(cyc - ls_cyc == D, "R4 first strobe delay", cyc - ls_cyc, D);
                else
                    chk(cyc - last_str == DIV, "R5 strobe spacing", cyc - last_str, DIV);
                chk(int'(pixel) == str_in_line, "R5 pixel index", int'(pixel), str_in_line);
                str_in_line++;
                last_str = cyc;
            end
            if (ld) begin
                n_done++;
                chk(str_in_line == P, "R6 strobes at line end", str_in_line, P);
                chk(cyc - last_str == DIV, "R6 done after last strobe", cyc - last_str, DIV);
            end
            if (fs) n_fs++;
        end
    end

    task automatic hold(input logic lv, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sync_n = lv;
        end
    endtask

    task automatic hline(input bit exp_ls, input int lowlen);
        @(negedge clk);
        sync_n = 1'b0;
        repeat (F + 4) @(negedge clk);
        chk(ls == exp_ls, "R2 line start timing", int'(ls), int'(exp_ls));
        if (exp_ls) begin
            @(negedge clk);
            chk(!ls, "R2 line start one cycle", int'(ls), 0);
            hold(1'b0, lowlen - F - 5);
        end else begin
            hold(1'b0, lowlen - F - 4);
        end
        hold(1'b1, 52);
    endtask

    task automatic t_reset;
        chk(!sample && !ls && !ld && !fs, "R1 strobes idle in reset",
            int'({sample, ls, ld, fs}), 0);
        chk(pixel == 0 && line == 0, "R1 counters zero in reset", int'({pixel, line}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!sample && !ls && !ld && !fs, "R1 idle after reset", int'({sample, ls, ld, fs}), 0);
    endtask

    task automatic t_preframe;
        int b = n_ls;
        hline(1'b0, 8);
        chk(n_ls == b, "R7 no line before first frame", n_ls - b, 0);
    endtask

    task automatic t_vsync;
        int bf = n_fs, bl = n_ls;
        hold(1'b0, 75);
        hold(1'b1, 5);
        hold(1'b0, 75);
        hold(1'b1, 60);
        chk(n_fs - bf == 1, "R8 one frame start", n_fs - bf, 1);
        chk(n_ls == bl, "R9 edges in vsync ignored", n_ls - bl, 0);
    endtask

    task automatic t_glitch;
        int bl = n_ls, bs = n_str;
        @(negedge clk);
        sync_n = 1'b0;
        hold(1'b0, 1);
        hold(1'b1, 30);
        chk(n_ls == bl, "R3 glitch no line start", n_ls - bl, 0);
        chk(n_str == bs, "R3 glitch no strobe", n_str - bs, 0);
    endtask

    task automatic t_lines;
        int bl = n_ls, bd = n_done, bs = n_str;
        hline(1'b0, 8);
        t_glitch();
        hline(1'b1, 8);
        hline(1'b1, 8);
        hline(1'b1, 8);
        hline(1'b0, 8);
        chk(n_ls - bl == ACT, "R7 active line count", n_ls - bl, ACT);
        for (int k = 0; k < ACT; k++)
            chk(lines_seen[bl + k] == k, "R7 line index", lines_seen[bl + k], k);
        chk(n_done - bd == ACT, "R6 done per line", n_done - bd, ACT);
        chk(n_str - bs == ACT * P, "R5 total strobes", n_str - bs, ACT * P);
    endtask

    task automatic t_short_low;
        int bf = n_fs;
        hline(1'b0, 50);
        chk(n_fs == bf, "R8 short low no frame", n_fs - bf, 0);
    endtask

    task automatic t_renumber;
        int bl;
        t_vsync();
        bl = n_ls;
        hline(1'b0, 8);
        hline(1'b1, 8);
        chk(n_ls - bl == 1, "R8 new frame line count", n_ls - bl, 1);
        chk(lines_seen[bl] == 0, "R8 numbering restarts", lines_seen[bl], 0);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
    end

    initial begin
        rst = 1'b1;
        sync_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        repeat (5) @(negedge clk);
        t_preframe();
        t_vsync();
        t_lines();
        t_short_low();
        t_renumber();
        repeat (10) @(negedge clk);
        summary();
    end

endmodule